// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block scans a square key matrix with a fixed number of row drive lines and column return lines. The rows are active-low outputs. The columns are inputs that idle high through external pull-ups, so a closed key pulls its column low only while its row is driven low. While the block waits, it drives every row low at once, so a closure anywhere in the matrix shows up as a low column. When it sees one, it waits a fixed debounce time. It then grounds one row at a time to find which key is closed.

When a closed key is found, the block emits a binary key number with a one-cycle strobe. It then holds off until the matrix has read fully open for a full debounce interval, and only then arms itself again. The columns pass through a two-flop stage before any logic uses them. Each scanned row is driven for a few settle cycles before its columns are judged. The debounce length is given in clock cycles; one hundredth of the clock rate gives 10 ms.

Top module: `kpd_scanner`

## Requirements
- R1: During reset and on the first cycle after it, all row outputs are low, `key_valid` is 0 and `key_code` is 0.
- R2: While waiting for a closure, all row outputs are driven low. As long as every column reads high (all ones means no key), no report is made and the rows stay low.
- R3: A report never comes earlier than DEBOUNCE_CYC clock cycles after the first low column starts the debounce interval.
- R4: During a scan, exactly one row is low at any time. The rows are visited in ascending index order, starting at row 0, and each is driven for SETTLE_CYC cycles before its columns are judged.
- R5: The reported code is row*COLS + column for the first low column found. Rows are examined from index 0 upward and columns within a row from index 0 upward. Binary code value 0 is row 0 / column 0, and 15 is row 3 / column 3 with the default 4x4 size.
- R6: If a full scan of all rows finds no low column, the block returns to the waiting state with all rows low and makes no report.
- R7: After a report, all rows are driven low and no further report is made until every column has read high for DEBOUNCE_CYC consecutive cycles. Any low column during that window restarts it, so a key that stays held is reported only once.
- R8: `key_valid` is high for exactly one cycle per report. `key_code` takes its new value in that cycle and holds it until the next report.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cols_in | input | COLS | Column return lines, low when a closed key meets a grounded row |
| rows_n | output | ROWS | Row drive lines, active low |
| key_valid | output | 1 | One-cycle strobe marking a new key code |
| key_code | output | $clog2(ROWS*COLS) | Binary number of the detected key |

## Verification
The hardest situation to reach from the ports is a release window that a bouncing key keeps restarting. Another is a held key that must never be reported twice. The bench reaches both by closing the key again part-way through the open-time window, and by pressing a second key before that window has run out. It then shows that a later clean press is still reported. A closure shorter than the debounce time makes a scan that finds nothing and must fall back quietly. Double presses within one row, and across rows, pin down the priority order.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

  typedef enum logic [2:0] {
    KS_WAIT    = 3'd0,
    KS_DBNC    = 3'd1,
    KS_SCAN    = 3'd2,
    KS_REPORT  = 3'd3,
    KS_RELEASE = 3'd4
  } kpd_state_e;

  // Linear key number: rows outer, columns inner.
  function automatic int unsigned kpd_key_index(input int unsigned row,
                                                input int unsigned col,
                                                input int unsigned ncols);
    return row * ncols + col;
  endfunction

endpackage

// File: rtl/kpd_sync.sv
module kpd_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '1;
      d_out  <= '1;
    end else begin
      stage1 <= d_in;
      d_out  <= stage1;
    end
  end

endmodule

// File: rtl/kpd_timer.sv
module kpd_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expired
);

  localparam int TW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= LAST;
    end else if (restart) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + TW'(1);
    end
  end

  assign expired = (cnt == LAST);

endmodule

// File: rtl/kpd_colenc.sv
module kpd_colenc #(
  parameter int COLS = 4
) (
  input  logic [COLS-1:0]                            cols_n,
  output logic                                       found,
  output logic [((COLS < 2) ? 1 : $clog2(COLS))-1:0] idx
);

  localparam int IW = (COLS < 2) ? 1 : $clog2(COLS);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    // Walk downward so the lowest low column wins.
    for (int c = COLS - 1; c >= 0; c--) begin
      if (!cols_n[c]) begin
        found = 1'b1;
        idx   = IW'(c);
      end
    end
  end

endmodule

// File: rtl/kpd_scanner.sv
module kpd_scanner #(
  parameter int ROWS         = 4,
  parameter int COLS         = 4,
  parameter int CLK_HZ       = 125_000_000,
  parameter int DEBOUNCE_CYC = CLK_HZ / 100,
  parameter int SETTLE_CYC   = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [COLS-1:0]                       cols_in,
  output logic [ROWS-1:0]                       rows_n,
  output logic                                  key_valid,
  output logic [$clog2(ROWS*COLS)-1:0]          key_code
);
  import kpd_pkg::*;

  localparam int CODE_W = $clog2(ROWS * COLS);
  localparam int ROW_W  = (ROWS < 2) ? 1 : $clog2(ROWS);
  localparam int COL_W  = (COLS < 2) ? 1 : $clog2(COLS);
  localparam int SET_W  = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);

  kpd_state_e        state, state_nx;
  logic [COLS-1:0]   cols_s;
  logic              any_low;
  logic              hit;
  logic [COL_W-1:0]  hit_col;
  logic [ROW_W-1:0]  row_idx;
  logic [SET_W-1:0]  settle;
  logic              tmr_restart;
  logic              tmr_expired;

  // Named events, also used by the bound checker.
  logic st_idle;
  logic st_release;
  logic dbnc_begin;
  logic sample_now;
  logic scan_hit;
  logic scan_miss;

  kpd_sync #(.WIDTH(COLS)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (cols_in),
    .d_out (cols_s)
  );

  kpd_colenc #(.COLS(COLS)) enc_i (
    .cols_n (cols_s),
    .found  (hit),
    .idx    (hit_col)
  );

  kpd_timer #(.LIMIT(DEBOUNCE_CYC)) tmr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .expired (tmr_expired)
  );

  assign any_low    = ~&cols_s;
  assign st_idle    = (state == KS_WAIT);
  assign st_release = (state == KS_RELEASE);
  assign dbnc_begin = st_idle && any_low;
  assign sample_now = (state == KS_SCAN) && (settle == SET_LAST);
  assign scan_hit   = sample_now && hit;
  assign scan_miss  = sample_now && !hit && (row_idx == ROW_LAST);

  assign tmr_restart = dbnc_begin
                     || (state == KS_REPORT)
                     || (st_release && any_low);

  always_comb begin
    state_nx = state;
    unique case (state)
      KS_WAIT:    if (any_low) state_nx = KS_DBNC;
      KS_DBNC:    if (tmr_expired) state_nx = KS_SCAN;
      KS_SCAN: begin
        if (scan_hit)       state_nx = KS_REPORT;
        else if (scan_miss) state_nx = KS_WAIT;
      end
      KS_REPORT:  state_nx = KS_RELEASE;
      KS_RELEASE: if (!any_low && tmr_expired) state_nx = KS_WAIT;
      default:    state_nx = KS_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= KS_WAIT;
    end else begin
      state <= state_nx;
    end
  end

  // Row walk and per-row settle count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_idx <= '0;
      settle  <= '0;
    end else if (state != KS_SCAN) begin
      row_idx <= '0;
      settle  <= '0;
    end else if (sample_now) begin
      settle <= '0;
      if (!hit && row_idx != ROW_LAST) row_idx <= row_idx + ROW_W'(1);
    end else begin
      settle <= settle + SET_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_code <= '0;
    end else if (scan_hit) begin
      key_code <= CODE_W'(kpd_key_index(32'(row_idx), 32'(hit_col), COLS));
    end
  end

  assign key_valid = (state == KS_REPORT);

  always_comb begin
    rows_n = '0;
    if (state == KS_SCAN) begin
      rows_n          = '1;
      rows_n[row_idx] = 1'b0;
    end
  end

endmodule

// File: rtl/kpd_scanner_chk.sv
module kpd_scanner_chk #(
  parameter int ROWS         = 4,
  parameter int COLS         = 4,
  parameter int DEBOUNCE_CYC = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [ROWS-1:0]              rows_n,
  input logic                         key_valid,
  input logic [$clog2(ROWS*COLS)-1:0] key_code,
  input logic                         st_idle,
  input logic                         st_release,
  input logic                         dbnc_begin,
  input logic                         scan_miss
);

  localparam int AW = $clog2(DEBOUNCE_CYC + 1);
  localparam logic [AW-1:0] AGE_MAX = AW'(DEBOUNCE_CYC);

  logic [AW-1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= '0;
    end else if (dbnc_begin) begin
      age <= '0;
    end else if (age != AGE_MAX) begin
      age <= age + AW'(1);
    end
  end

  assert_rows_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rows_n == '0) || $onehot(~rows_n));

  assert_idle_rows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> (rows_n == '0));

  assert_report_late_R3: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (age == AGE_MAX));

  assert_miss_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_miss |=> (st_idle && !key_valid));

  assert_release_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_release |-> (!key_valid && rows_n == '0));

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid);

  assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |-> $stable(key_code));

endmodule

bind kpd_scanner kpd_scanner_chk #(
  .ROWS(ROWS), .COLS(COLS), .DEBOUNCE_CYC(DEBOUNCE_CYC)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rows_n     (rows_n),
  .key_valid  (key_valid),
  .key_code   (key_code),
  .st_idle    (st_idle),
  .st_release (st_release),
  .dbnc_begin (dbnc_begin),
  .scan_miss  (scan_miss)
);

// File: tb/kpd_scanner_tb.sv
module kpd_scanner_tb_top;

  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int DBC  = 20;
  localparam int SETL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cols_in;
  logic [3:0]  rows_n;
  logic        key_valid;
  logic [3:0]  key_code;
  logic [15:0] pressed = '0;

  int tests = 0;
  int fails = 0;
  int row_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  kpd_scanner #(
    .ROWS(ROWS), .COLS(COLS), .CLK_HZ(2000), .DEBOUNCE_CYC(DBC), .SETTLE_CYC(SETL)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cols_in   (cols_in),
    .rows_n    (rows_n),
    .key_valid (key_valid),
    .key_code  (key_code)
  );

  // Matrix model: a closed key pulls its column low while its row is low.
  always_comb begin
    cols_in = '1;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (pressed[r*COLS + c] && !rows_n[r]) cols_in[c] = 1'b0;
  end

  // Row monitor: never two rows low, and scan rows ascend (R4).
  int last_row = -1;
  always @(negedge clk) begin
    if (rst_n) begin
      int lows = 0;
      int which = -1;
      for (int r = 0; r < ROWS; r++) if (!rows_n[r]) begin lows++; which = r; end
      if (lows > 1 && lows < ROWS) row_err++;
      if (lows == 1) begin
        if (which != last_row && which != last_row + 1) row_err++;
        last_row = which;
      end else begin
        last_row = -1;
        if (lows == ROWS && which != ROWS - 1) row_err++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_for(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (key_valid) seen++;
    end
  endtask

  task automatic wait_report(input int lim, output bit got, output int lat);
    got = 1'b0;
    lat = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      lat++;
      if (key_valid) begin got = 1'b1; break; end
    end
  endtask

  task automatic release_all();
    int seen;
    pressed = '0;
    idle_for(DBC + 12, seen);
    check(seen == 0 && rows_n == 4'h0, "R7 re-arm after release", seen, 0);
  endtask

  task automatic t_reset();
    check(rows_n == 4'h0, "R1 rows during reset", rows_n, 0);
    check(key_valid == 1'b0, "R1 valid during reset", key_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rows_n == 4'h0 && key_valid == 1'b0 && key_code == 4'h0,
          "R1 state after reset", {rows_n, key_valid, key_code}, 0);
  endtask

  task automatic t_quiet();
    int seen = 0;
    int bad = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (key_valid) seen++;
      if (rows_n != 4'h0) bad++;
    end
    check(seen == 0, "R2 no report with open matrix", seen, 0);
    check(bad == 0, "R2 rows low while waiting", bad, 0);
  endtask

  task automatic t_single(input int r, input int c);
    bit got;
    int lat;
    int seen;
    int code_at;
    pressed[r*COLS + c] = 1'b1;
    wait_report(600, got, lat);
    check(got, "R5 key reported", got, 1);
    check(int'(key_code) == r*COLS + c, "R5 key code", key_code, r*COLS + c);
    check(lat >= DBC, "R3 debounce latency", lat, DBC);
    code_at = key_code;
    @(negedge clk);
    check(!key_valid && int'(key_code) == code_at, "R8 single pulse, code held",
          {key_valid, key_code}, code_at);
    idle_for(300, seen);
    check(seen == 0 && rows_n == 4'h0, "R7 held key reported once", seen, 0);
    release_all();
  endtask

  task automatic t_pair(input int k0, input int k1, input int exp);
    bit got;
    int lat;
    pressed[k0] = 1'b1;
    pressed[k1] = 1'b1;
    wait_report(600, got, lat);
    check(got && int'(key_code) == exp, "R5 priority of two keys", key_code, exp);
    release_all();
  endtask

  task automatic t_glitch();
    int seen;
    bit got;
    int lat;
    pressed[6] = 1'b1;
    repeat (5) @(negedge clk);
    pressed = '0;
    idle_for(200, seen);
    check(seen == 0, "R6 short closure gives no report", seen, 0);
    check(rows_n == 4'h0, "R6 back to waiting, rows low", rows_n, 0);
    pressed[11] = 1'b1;
    wait_report(600, got, lat);
    check(got && key_code == 4'd11, "R6 armed again after empty scan", key_code, 11);
    release_all();
  endtask

  task automatic t_bounce();
    bit got;
    int lat;
    int seen;
    pressed[5] = 1'b1;
    wait_report(600, got, lat);
    check(got && key_code == 4'd5, "R5 first key before bounce", key_code, 5);
    pressed = '0;
    idle_for(DBC / 2, seen);
    pressed[5] = 1'b1;
    idle_for(3, seen);
    pressed = '0;
    idle_for(DBC / 2, seen);
    pressed[9] = 1'b1;
    idle_for(200, seen);
    check(seen == 0, "R7 press inside open window not reported", seen, 0);
    check(key_code == 4'd5, "R8 code held while suppressed", key_code, 5);
    release_all();
    pressed[7] = 1'b1;
    wait_report(600, got, lat);
    check(got && key_code == 4'd7, "R7 clean press after window", key_code, 7);
    release_all();
  endtask

  initial begin
    t_reset();
    t_quiet();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        t_single(r, c);
    t_pair(6, 4, 4);
    t_pair(9, 12, 9);
    t_pair(15, 3, 3);
    t_glitch();
    t_bounce();
    check(row_err == 0, "R4 one row at a time, ascending", row_err, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule